// File: doc/BRIEF.md
# Two-base delta line codec

This block packs a 64-byte cache line into a short form for a compressed last-level cache, and unpacks that form back into the full line. The compressor cuts the line into equal words and tries to write every word as a small signed offset. Each word may take its offset from one of two bases. One is an explicit base taken from the line itself. The other is an implicit zero. A per-word select bit records which base applies, so a line that mixes large values (pointers, for example) with small integers can still compress.

The compressor tries several word and offset sizes side by side and keeps the shortest form that fits. All-zero lines and lines that repeat one 64-bit value use dedicated short forms. A line that fits none of the forms is passed through unchanged. Results leave through a single output register with a valid/ready handshake.

The decompressor rebuilds every word of the line in parallel. Its result is registered and appears one cycle after its input is presented.

Top module: `bdi_codec`

## Requirements
- R1: An all-zero input line is encoded as code 0, with size 0 and with base, deltas and mask all zero.
- R2: A line that is not all zero, and whose eight 64-bit words are all equal, is encoded as code 1. Its base is that 64-bit value, its size is 8, and its deltas and mask are zero.
- R3: Word i of the line is bytes [i*W, i*W+W), little-endian. A word fits a delta width of D bytes when sign-extending its low D bytes gives back the whole word. The explicit base is the lowest-index word that does not fit against zero. If every word fits against zero, the explicit base is 0. A word that fits against zero uses the zero base and sets mask bit i to 0. Any other word sets mask bit i to 1 and stores (word - base) modulo 2^(8W), which must also fit.
- R4: The forms are tried in this order. Code 2: 8-byte words, 1-byte deltas, size 16. Code 3: 4-byte words, 1-byte deltas, size 20. Code 4: 8-byte words, 2-byte deltas, size 24. Code 5: 4-byte words, 2-byte deltas, size 36. Code 6: 8-byte words, 4-byte deltas, size 40. Codes 0 and 1 take precedence over all of these. The lowest code whose form fits is chosen. Size is W + (64/W)*D bytes.
- R5: A line that fits no form gets code 15 and size 64. Its deltas field holds the raw line, and its base and mask are zero.
- R6: The delta of word i is stored at bits [i*8D +: 8D] of the deltas field, and the unused upper bits are zero. The base sits in the low 8W bits of the base field, with the upper bits zero. Mask bits at or above the word count are zero.
- R7: c_in_ready is high when the output register is empty or c_out_ready is high. An accepted line shows on the outputs in the next cycle. While c_out_valid is high and c_out_ready is low, all outputs hold.
- R8: One cycle after d_in_valid, d_out_valid is high and d_out_line holds the rebuilt line for codes 0 to 6 and 15. For codes 2 to 6, each word is (mask bit ? base : 0) plus the sign-extended delta, taken modulo the word width.
- R9: Decompressing any compressor output gives back the original line.
- R10: While reset is asserted, c_out_valid and d_out_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| c_in_valid | input | 1 | Line to compress is present |
| c_in_ready | output | 1 | Compressor can accept a line |
| c_in_line | input | 512 | Uncompressed line |
| c_out_valid | output | 1 | Compressed result is valid |
| c_out_ready | input | 1 | Consumer takes the result |
| c_out_enc | output | 4 | Chosen form code |
| c_out_base | output | 64 | Explicit base or repeated value |
| c_out_deltas | output | 512 | Packed deltas, or the raw line for code 15 |
| c_out_mask | output | 16 | Per-word base select (1 = explicit base) |
| c_out_size | output | 7 | Compressed size in bytes |
| d_in_valid | input | 1 | Compressed form to rebuild is present |
| d_in_enc | input | 4 | Form code |
| d_in_base | input | 64 | Base field |
| d_in_deltas | input | 512 | Deltas field |
| d_in_mask | input | 16 | Base-select mask |
| d_out_valid | output | 1 | Rebuilt line is valid |
| d_out_line | output | 512 | Rebuilt line |

## Verification
The bench builds the codec with LINE_BYTES at its default of 64, which gives eight 8-byte words or sixteen 4-byte words and a 16-bit mask. This brings both word sizes and all three delta widths into one run. Random lines are built from a chosen base, offsets at and just past each delta width's limits, and small immediates mixed in. This exercises the choice of explicit base, the ordering of the forms and wrap-around subtraction. Every result is also fed back through the decompressor to confirm the round trip.

// File: rtl/bdi_pkg.sv
package bdi_pkg;

  typedef enum logic [3:0] {
    ENC_ZERO = 4'd0,
    ENC_REP  = 4'd1,
    ENC_B8D1 = 4'd2,
    ENC_B4D1 = 4'd3,
    ENC_B8D2 = 4'd4,
    ENC_B4D2 = 4'd5,
    ENC_B8D4 = 4'd6,
    ENC_RAW  = 4'd15
  } bdi_enc_e;

  // number of base+delta forms; form k carries code k+2
  localparam int NCFG = 5;

  function automatic int cfg_word_bytes(input int k);
    return (k == 1 || k == 3) ? 4 : 8;
  endfunction

  function automatic int cfg_delta_bytes(input int k);
    return (k < 2) ? 1 : (k < 4) ? 2 : 4;
  endfunction

  function automatic int cfg_size(input int k, input int line_bytes);
    return cfg_word_bytes(k) + (line_bytes / cfg_word_bytes(k)) * cfg_delta_bytes(k);
  endfunction

endpackage

// File: rtl/bdi_fit.sv
// One base+delta form: finds the explicit base, the select mask and the
// packed deltas, and reports whether every word fits.
module bdi_fit #(
  parameter int LINE_BYTES  = 64,
  parameter int WORD_BYTES  = 8,
  parameter int DELTA_BYTES = 1,
  parameter int MASK_W      = 16
) (
  input  logic [LINE_BYTES*8-1:0] line_i,
  output logic                    fits_o,
  output logic [63:0]             base_o,
  output logic [LINE_BYTES*8-1:0] deltas_o,
  output logic [MASK_W-1:0]       mask_o
);
  localparam int WBITS = WORD_BYTES * 8;
  localparam int DBITS = DELTA_BYTES * 8;
  localparam int NW    = LINE_BYTES / WORD_BYTES;

  logic [NW-1:0]    zfit;
  logic [NW-1:0]    bfit;
  logic [WBITS-1:0] base_w;

  function automatic logic narrow(input logic [WBITS-1:0] v);
    return (&v[WBITS-1:DBITS-1]) | ~(|v[WBITS-1:DBITS-1]);
  endfunction

  always_comb begin
    logic [WBITS-1:0] w;
    logic [WBITS-1:0] d;
    for (int i = 0; i < NW; i++) zfit[i] = narrow(line_i[i*WBITS +: WBITS]);
    base_w = '0;
    for (int i = NW - 1; i >= 0; i--)
      if (!zfit[i]) base_w = line_i[i*WBITS +: WBITS];
    deltas_o = '0;
    mask_o   = '0;
    for (int i = 0; i < NW; i++) begin
      w         = line_i[i*WBITS +: WBITS];
      d         = w - base_w;
      bfit[i]   = narrow(d);
      mask_o[i] = !zfit[i];
      deltas_o[i*DBITS +: DBITS] = zfit[i] ? w[DBITS-1:0] : d[DBITS-1:0];
    end
    fits_o = &(zfit | bfit);
    base_o = 64'(base_w);
  end

endmodule

// File: rtl/bdi_comp.sv
module bdi_comp
  import bdi_pkg::*;
#(
  parameter int LINE_BYTES = 64,
  parameter int MASK_W     = 16,
  parameter int SZW        = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [LINE_BYTES*8-1:0] in_line,
  output logic                    out_valid,
  input  logic                    out_ready,
  output bdi_enc_e                enc_q,
  output logic [63:0]             base_q,
  output logic [LINE_BYTES*8-1:0] deltas_q,
  output logic [MASK_W-1:0]       mask_q,
  output logic [SZW-1:0]          size_q
);
  localparam int LBITS = LINE_BYTES * 8;
  localparam int NW8   = LINE_BYTES / 8;

  logic [NCFG-1:0]   fit_v;
  logic [63:0]       base_a [NCFG];
  logic [LBITS-1:0]  del_a  [NCFG];
  logic [MASK_W-1:0] mask_a [NCFG];

  for (genvar k = 0; k < NCFG; k++) begin : g_form
    bdi_fit #(
      .LINE_BYTES (LINE_BYTES),
      .WORD_BYTES (cfg_word_bytes(k)),
      .DELTA_BYTES(cfg_delta_bytes(k)),
      .MASK_W     (MASK_W)
    ) u_fit (
      .line_i  (in_line),
      .fits_o  (fit_v[k]),
      .base_o  (base_a[k]),
      .deltas_o(del_a[k]),
      .mask_o  (mask_a[k])
    );
  end

  logic             all_zero, all_rep;
  bdi_enc_e         n_enc;
  logic [63:0]      n_base;
  logic [LBITS-1:0] n_del;
  logic [MASK_W-1:0] n_mask;
  logic [SZW-1:0]   n_size;
  logic             take, v_d;

  always_comb begin
    all_zero = ~|in_line;
    all_rep  = 1'b1;
    for (int i = 1; i < NW8; i++)
      if (in_line[i*64 +: 64] != in_line[63:0]) all_rep = 1'b0;
    n_enc  = ENC_RAW;
    n_base = '0;
    n_del  = in_line;
    n_mask = '0;
    n_size = SZW'(LINE_BYTES);
    for (int k = NCFG - 1; k >= 0; k--) begin
      if (fit_v[k]) begin
        n_enc  = bdi_enc_e'(4'(k + 2));
        n_base = base_a[k];
        n_del  = del_a[k];
        n_mask = mask_a[k];
        n_size = SZW'(cfg_size(k, LINE_BYTES));
      end
    end
    if (all_rep) begin
      n_enc  = ENC_REP;
      n_base = in_line[63:0];
      n_del  = '0;
      n_mask = '0;
      n_size = SZW'(8);
    end
    if (all_zero) begin
      n_enc  = ENC_ZERO;
      n_base = '0;
      n_del  = '0;
      n_mask = '0;
      n_size = '0;
    end
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_comb begin
    v_d = out_valid;
    if (take) v_d = 1'b1;
    else if (out_ready) v_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= v_d;
  end

  always_ff @(posedge clk) begin
    if (take) begin
      enc_q    <= n_enc;
      base_q   <= n_base;
      deltas_q <= n_del;
      mask_q   <= n_mask;
      size_q   <= n_size;
    end
  end

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(enc_q) && $stable(base_q)
      && $stable(deltas_q) && $stable(mask_q) && $stable(size_q));

  // R5
  raw_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && enc_q == ENC_RAW |-> size_q == SZW'(LINE_BYTES) && mask_q == '0);

  // R1
  zero_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && enc_q == ENC_ZERO |-> size_q == '0 && base_q == '0 && deltas_q == '0);

  // R6
  mask_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (enc_q == ENC_B8D1 || enc_q == ENC_B8D2 || enc_q == ENC_B8D4)
      |-> mask_q[MASK_W-1:NW8] == '0);

endmodule

// File: rtl/bdi_decomp.sv
module bdi_decomp
  import bdi_pkg::*;
#(
  parameter int LINE_BYTES = 64,
  parameter int MASK_W     = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [3:0]              enc_i,
  input  logic [63:0]             base_i,
  input  logic [LINE_BYTES*8-1:0] deltas_i,
  input  logic [MASK_W-1:0]       mask_i,
  output logic                    out_valid,
  output logic [LINE_BYTES*8-1:0] line_q
);
  localparam int LBITS = LINE_BYTES * 8;

  logic [LBITS-1:0] cand [NCFG];
  logic [LBITS-1:0] n_line;

  for (genvar k = 0; k < NCFG; k++) begin : g_form
    localparam int WB = cfg_word_bytes(k) * 8;
    localparam int DB = cfg_delta_bytes(k) * 8;
    localparam int NW = LINE_BYTES / cfg_word_bytes(k);
    logic [LBITS-1:0] rebuilt;
    always_comb begin
      logic [WB-1:0] d;
      rebuilt = '0;
      for (int i = 0; i < NW; i++) begin
        d = {{(WB-DB){deltas_i[i*DB+DB-1]}}, deltas_i[i*DB +: DB]};
        rebuilt[i*WB +: WB] = (mask_i[i] ? base_i[WB-1:0] : '0) + d;
      end
    end
    assign cand[k] = rebuilt;
  end

  always_comb begin
    n_line = '0;
    case (enc_i)
      ENC_ZERO: n_line = '0;
      ENC_REP:  n_line = {(LINE_BYTES/8){base_i}};
      ENC_RAW:  n_line = deltas_i;
      default:
        for (int k = 0; k < NCFG; k++)
          if (enc_i == 4'(k + 2)) n_line = cand[k];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) line_q <= n_line;
  end

  // R8
  dvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid));

  // R8
  zero_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && enc_i == ENC_ZERO |=> line_q == '0);

endmodule

// File: rtl/bdi_codec.sv
module bdi_codec
  import bdi_pkg::*;
#(
  parameter int LINE_BYTES = 64,
  parameter int MASK_W     = LINE_BYTES / 4,
  parameter int SZW        = $clog2(LINE_BYTES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    c_in_valid,
  output logic                    c_in_ready,
  input  logic [LINE_BYTES*8-1:0] c_in_line,
  output logic                    c_out_valid,
  input  logic                    c_out_ready,
  output logic [3:0]              c_out_enc,
  output logic [63:0]             c_out_base,
  output logic [LINE_BYTES*8-1:0] c_out_deltas,
  output logic [MASK_W-1:0]       c_out_mask,
  output logic [SZW-1:0]          c_out_size,
  input  logic                    d_in_valid,
  input  logic [3:0]              d_in_enc,
  input  logic [63:0]             d_in_base,
  input  logic [LINE_BYTES*8-1:0] d_in_deltas,
  input  logic [MASK_W-1:0]       d_in_mask,
  output logic                    d_out_valid,
  output logic [LINE_BYTES*8-1:0] d_out_line
);
  logic [1:0] rst_sync;
  logic       core_rst_n;
  bdi_enc_e   enc_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign core_rst_n = rst_sync[1];

  bdi_comp #(.LINE_BYTES(LINE_BYTES), .MASK_W(MASK_W), .SZW(SZW)) u_comp (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .in_valid (c_in_valid),
    .in_ready (c_in_ready),
    .in_line  (c_in_line),
    .out_valid(c_out_valid),
    .out_ready(c_out_ready),
    .enc_q    (enc_q),
    .base_q   (c_out_base),
    .deltas_q (c_out_deltas),
    .mask_q   (c_out_mask),
    .size_q   (c_out_size)
  );
  assign c_out_enc = enc_q;

  bdi_decomp #(.LINE_BYTES(LINE_BYTES), .MASK_W(MASK_W)) u_decomp (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .in_valid (d_in_valid),
    .enc_i    (d_in_enc),
    .base_i   (d_in_base),
    .deltas_i (d_in_deltas),
    .mask_i   (d_in_mask),
    .out_valid(d_out_valid),
    .line_q   (d_out_line)
  );

endmodule

// File: tb/sim_bdi_codec.sv
`timescale 1ns/1ps
module sim_bdi_codec;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         c_in_valid, c_in_ready, c_out_valid, c_out_ready;
  logic [511:0] c_in_line, c_out_deltas;
  logic [3:0]   c_out_enc;
  logic [63:0]  c_out_base;
  logic [15:0]  c_out_mask;
  logic [6:0]   c_out_size;
  logic         d_in_valid, d_out_valid;
  logic [3:0]   d_in_enc;
  logic [63:0]  d_in_base;
  logic [511:0] d_in_deltas, d_out_line;
  logic [15:0]  d_in_mask;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  bdi_codec u0 (.*);

  task automatic check(input bit ok, input string tag, input logic [511:0] act, input logic [511:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic longint wrapw(input longint v, input int wb);
    if (wb == 4) return longint'($signed(v[31:0]));
    return v;
  endfunction

  function automatic bit in_range(input longint v, input int db);
    longint lim = longint'(1) << (db * 8 - 1);
    return (v >= -lim) && (v < lim);
  endfunction

  function automatic longint word_of(input logic [511:0] ln, input int i, input int wb);
    logic [511:0] s = ln >> (i * wb * 8);
    return wrapw(longint'(s[63:0]), wb);
  endfunction

  // independent model of R1..R6
  function automatic void ref_comp(input logic [511:0] ln, output logic [3:0] e,
      output logic [63:0] b, output logic [511:0] dl, output logic [15:0] m, output logic [6:0] sz);
    bit rep = 1;
    for (int i = 1; i < 8; i++) if (ln[i*64 +: 64] != ln[63:0]) rep = 0;
    e = 4'd15; b = '0; dl = ln; m = '0; sz = 7'd64;
    if (ln == '0) begin e = 0; dl = '0; sz = 0; return; end
    if (rep) begin e = 1; b = ln[63:0]; dl = '0; sz = 8; return; end
    for (int k = 0; k < 5; k++) begin
      int wb = (k == 1 || k == 3) ? 4 : 8;
      int db = (k < 2) ? 1 : (k < 4) ? 2 : 4;
      int nw = 64 / wb;
      longint bv = 0;
      bit ok = 1, got = 0;
      logic [511:0] tdl = '0;
      logic [15:0] tm = '0;
      for (int i = 0; i < nw; i++)
        if (!got && !in_range(word_of(ln, i, wb), db)) begin bv = word_of(ln, i, wb); got = 1; end
      for (int i = 0; i < nw; i++) begin
        longint v = word_of(ln, i, wb);
        longint dv;
        if (in_range(v, db)) dv = v;
        else begin dv = wrapw(v - bv, wb); tm[i] = 1'b1; if (!in_range(dv, db)) ok = 0; end
        tdl = tdl | ((512'(dv) & ((512'(1) << (db * 8)) - 1)) << (i * db * 8));
      end
      if (ok) begin
        e = 4'(k + 2); dl = tdl; m = tm; sz = 7'(wb + nw * db);
        b = (wb == 4) ? {32'd0, bv[31:0]} : bv;
        return;
      end
    end
  endfunction

  task automatic run_vec(input logic [511:0] ln, input string tag);
    logic [3:0] e; logic [63:0] b; logic [511:0] dl; logic [15:0] m; logic [6:0] sz;
    ref_comp(ln, e, b, dl, m, sz);
    @(negedge clk); c_in_line = ln; c_in_valid = 1; c_out_ready = 1;
    @(negedge clk); c_in_valid = 0;
    check(c_out_valid === 1'b1, "R7 out_valid", 512'(c_out_valid), 1);
    check(c_out_enc === e, {tag, " R4 enc"}, 512'(c_out_enc), 512'(e));
    check(c_out_size === sz, {tag, " R4 size"}, 512'(c_out_size), 512'(sz));
    check(c_out_base === b, {tag, " R3 base"}, 512'(c_out_base), 512'(b));
    check(c_out_mask === m, {tag, " R3 mask"}, 512'(c_out_mask), 512'(m));
    check(c_out_deltas === dl, {tag, " R6 deltas"}, c_out_deltas, dl);
    d_in_enc = c_out_enc; d_in_base = c_out_base; d_in_deltas = c_out_deltas;
    d_in_mask = c_out_mask; d_in_valid = 1;
    @(negedge clk); d_in_valid = 0;
    check(d_out_valid === 1'b1, "R8 d_out_valid", 512'(d_out_valid), 1);
    check(d_out_line === ln, "R9 round trip", d_out_line, ln);
  endtask

  function automatic logic [511:0] gen_line();
    logic [511:0] ln = '0;
    int mode = $urandom % 6;
    int wb   = ($urandom % 2) ? 8 : 4;
    int db   = (wb == 4) ? (1 + $urandom % 2) : (1 << ($urandom % 3));
    longint bv = longint'({$urandom, $urandom});
    longint lim = longint'(1) << (db * 8 - 1);
    if (mode == 0) begin
      for (int i = 0; i < 16; i++) ln[i*32 +: 32] = $urandom;
      return ln;
    end
    if (mode == 1) return {8{bv}};
    for (int i = 0; i < 64 / wb; i++) begin
      longint v;
      int pick = $urandom % 8;
      if (pick == 0)      v = longint'($urandom % 200) - 100;
      else if (pick == 1) v = bv + lim - 1;
      else if (pick == 2) v = bv - lim;
      else if (pick == 3 && mode == 5) v = bv + lim;
      else                v = bv + (longint'($urandom) % lim);
      ln = ln | ((512'(v) & ((512'(1) << (wb * 8)) - 1)) << (i * wb * 8));
    end
    return ln;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [511:0] ln, la, lb, exp_l;
    logic [3:0] e; logic [63:0] b; logic [511:0] dl; logic [15:0] m; logic [6:0] sz;
    void'($urandom(32'd20240611));
    rst_n = 0; c_in_valid = 0; c_out_ready = 0; c_in_line = '0;
    d_in_valid = 0; d_in_enc = '0; d_in_base = '0; d_in_deltas = '0; d_in_mask = '0;
    repeat (3) @(negedge clk);
    check(c_out_valid === 1'b0, "R10 c_out_valid", 512'(c_out_valid), 0);
    check(d_out_valid === 1'b0, "R10 d_out_valid", 512'(d_out_valid), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // directed corner cases
    run_vec('0, "R1 zero line");
    check(c_out_size === 7'd0 && c_out_enc === 4'd0, "R1 zero form", 512'(c_out_size), 0);
    run_vec({8{64'hDEAD_BEEF_0123_4567}}, "R2 repeat");
    check(c_out_enc === 4'd1 && c_out_size === 7'd8, "R2 repeat form", 512'(c_out_enc), 1);
    ln = '0;
    for (int i = 0; i < 8; i++) ln[i*64 +: 64] = 64'h4000_0000_0000_0000 + 64'(i * 18) - 64'd128;
    ln[64 +: 64] = 64'd3;
    run_vec(ln, "R3 base plus immediate");
    check(c_out_enc === 4'd2 && c_out_mask === 16'h00FD, "R3 mixed mask", 512'(c_out_mask), 512'(16'h00FD));
    ln = '0;
    for (int i = 0; i < 8; i++) ln[i*64 +: 64] = 64'h7FFF_FFFF_FFFF_FFF0 + 64'(i * 4);
    run_vec(ln, "R3 wrap");
    for (int i = 0; i < 16; i++) ln[i*32 +: 32] = 32'h0001_0000 + 32'(i * 100);
    run_vec(ln, "R4 four-byte words");
    for (int i = 0; i < 16; i++) ln[i*32 +: 32] = 32'h1234_5678 * 32'(i + 1);
    run_vec(ln, "R5 incompressible");
    check(c_out_enc === 4'd15 && c_out_deltas === ln, "R5 raw pass", 512'(c_out_enc), 15);

    // R8: hand-built 4-byte/1-byte form, word0 = 0x1000 + (-1), word1 = 0 + 5
    @(negedge clk);
    d_in_enc = 4'd3; d_in_base = 64'h1000; d_in_mask = 16'h0001;
    d_in_deltas = '0; d_in_deltas[7:0] = 8'hFF; d_in_deltas[15:8] = 8'h05; d_in_valid = 1;
    @(negedge clk); d_in_valid = 0;
    exp_l = '0; exp_l[31:0] = 32'h0FFF; exp_l[63:32] = 32'd5;
    check(d_out_line === exp_l, "R8 direct rebuild", d_out_line, exp_l);

    // R7: stall then release
    la = {8{64'h0000_0000_0000_1111}} ^ 512'd7;
    lb = '0; lb[63:0] = 64'd9;
    @(negedge clk); c_out_ready = 0; c_in_line = la; c_in_valid = 1;
    @(negedge clk); c_in_line = lb;
    check(c_in_ready === 1'b0, "R7 ready low when full", 512'(c_in_ready), 0);
    ref_comp(la, e, b, dl, m, sz);
    @(negedge clk);
    check(c_out_valid === 1'b1 && c_out_deltas === dl && c_out_enc === e, "R7 hold while stalled", c_out_deltas, dl);
    c_out_ready = 1;
    @(negedge clk); c_in_valid = 0;
    ref_comp(lb, e, b, dl, m, sz);
    check(c_out_enc === e && c_out_deltas === dl, "R7 next after release", c_out_deltas, dl);

    // constrained random
    for (int n = 0; n < 400; n++) run_vec(gen_line(), "random");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule